// File: doc/BRIEF.md
# Rotating-Window Register File

This block is a register file that renames part of its address space. The logical address space has two parts. The lower part holds static registers that always map to the same storage entry. Above it sits a rotating window of `ROT_SIZE` registers. Each access to the window goes through a base offset, and every rotation moves that offset down by one. A value that a loop writes under one window name can therefore be read one name higher after each rotation. This lets the stages of a software-pipelined loop body keep the same register names from pass to pass while their data moves along.

The file has one write port and two read ports, all addressed by logical number. Reads are combinational on the current base. Writes land on the clock edge. A rotate input steps the base down, and a clear input puts the base back to zero without touching any stored data. The storage is a plain array with no reset, so an FPGA tool can map it to distributed memory. Logical numbers at or above the window top do not exist.

Top module: `rrf_rotating_file`

## Requirements
- R1: Logical registers 0 to ROT_START-1 (0 to 31 by default) are static. A write to one of them is read back from the same number, and no rotation or base clear ever changes which entry they address.
- R2: Window register at logical number L (ROT_START ≤ L < ROT_START+ROT_SIZE) addresses entry ROT_START + ((L − ROT_START + base) mod ROT_SIZE), where base is a $clog2(ROT_SIZE)-bit register. While the base is unchanged, a value written at a window number is read back from that same number.
- R3: A cycle with rot_en=1 and base_clr=0 decrements the base by one, modulo ROT_SIZE, effective from the next cycle. After that, logical number L+1 returns what L returned before the rotation.
- R4: Rotation wraps: after one rotation, the lowest window number (32) returns what the highest window number (ROT_START+ROT_SIZE-1, 39 by default) held before it.
- R5: A write in the same cycle as a rotation is placed using the base from before the rotation. So a write to 32 with rot_en=1 reads back from 33 in the next cycle.
- R6: Reads are combinational. A read of the entry being written in the same cycle returns the old value, and the new value appears right after the clock edge.
- R7: base_clr=1 sets the base to 0 on the next edge, taking priority over rot_en. Stored data is not changed.
- R8: Logical numbers at or above ROT_START+ROT_SIZE (40 by default) are out of range. A write to one is dropped and touches no register, and a read returns zero.
- R9: Synchronous active-high rst sets the base to 0. Stored data survives the reset.
- R10: ROT_SIZE successive rotations bring the base back to its starting value, so every window number returns its original value again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the base |
| rot_en | input | 1 | Decrement the rotating base at this edge |
| base_clr | input | 1 | Force the base to zero at this edge (wins over rot_en) |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Logical write number |
| wr_data | input | DATA_W | Write data |
| rd0_addr | input | ADDR_W | Logical number, read port 0 |
| rd0_data | output | DATA_W | Read port 0 data (combinational) |
| rd1_addr | input | ADDR_W | Logical number, read port 1 |
| rd1_data | output | DATA_W | Read port 1 data (combinational) |

## Verification
Two kinds of collision can fall in one cycle: a write and a rotation, and a write and a read of the same entry. The bench forces both. It raises rot_en together with a write to window number 32, then reads 33 and 32 in the next cycle, expecting the new data at 33 and the old top entry at 32. For the read collision, it holds a read address on the entry being written and samples before and after the edge, expecting the old value and then the new one. It also raises base_clr together with rot_en and checks that the clear wins, by reading the window at base zero.

// File: rtl/rrf_pkg.sv
package rrf_pkg;

  typedef enum logic [1:0] {
    BASE_HOLD = 2'd0,
    BASE_DEC  = 2'd1,
    BASE_ZERO = 2'd2
  } base_op_e;

  function automatic base_op_e pick_base_op(input logic rst, input logic clr,
                                            input logic rot);
    if (rst || clr) return BASE_ZERO;
    if (rot)        return BASE_DEC;
    return BASE_HOLD;
  endfunction

endpackage

// File: rtl/rrf_base_ctr.sv
module rrf_base_ctr #(
  parameter int BASE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_clr,
  input  logic              rot_en,
  output logic [BASE_W-1:0] base_q
);
  import rrf_pkg::*;

  base_op_e op;

  always_comb op = pick_base_op(rst, base_clr, rot_en);

  always_ff @(posedge clk) begin
    case (op)
      BASE_ZERO: base_q <= '0;
      BASE_DEC:  base_q <= base_q - 1'b1;
      default:   base_q <= base_q;
    endcase
  end
endmodule

// File: rtl/rrf_map.sv
module rrf_map #(
  parameter int ADDR_W    = 6,
  parameter int ROT_START = 32,
  parameter int ROT_SIZE  = 8,
  parameter int BASE_W    = 3
) (
  input  logic [ADDR_W-1:0] log_addr,
  input  logic [BASE_W-1:0] base,
  output logic [ADDR_W-1:0] phys_addr,
  output logic              in_range
);
  localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(ROT_START);
  localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(ROT_START + ROT_SIZE);

  logic [ADDR_W:0]   wide;
  logic [ADDR_W-1:0] rel;
  logic [BASE_W-1:0] slot;

  always_comb begin
    wide = {1'b0, log_addr};
    rel  = log_addr - ADDR_W'(ROT_START);
    slot = rel[BASE_W-1:0] + base;
    if (wide < LO) begin
      phys_addr = log_addr;
      in_range  = 1'b1;
    end else if (wide < HI) begin
      phys_addr = ADDR_W'(ROT_START) + ADDR_W'(slot);
      in_range  = 1'b1;
    end else begin
      phys_addr = '0;
      in_range  = 1'b0;
    end
  end
endmodule

// File: rtl/rrf_storage.sv
module rrf_storage #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 40,
  parameter int NRD    = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr [NRD],
  output logic [DATA_W-1:0] rdata [NRD]
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata[r] = mem[raddr[r]];
  end
endmodule

// File: rtl/rrf_rotating_file.sv
module rrf_rotating_file #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 6,
  parameter int ROT_START = 32,
  parameter int ROT_SIZE  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rot_en,
  input  logic              base_clr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd0_addr,
  output logic [DATA_W-1:0] rd0_data,
  input  logic [ADDR_W-1:0] rd1_addr,
  output logic [DATA_W-1:0] rd1_data
);
  localparam int BASE_W = $clog2(ROT_SIZE);
  localparam int DEPTH  = ROT_START + ROT_SIZE;
  localparam int NPORT  = 3;   // port 0 = write, ports 1..2 = reads
  localparam int NRD    = NPORT - 1;

  logic [BASE_W-1:0] base_q;
  logic [ADDR_W-1:0] log_a  [NPORT];
  logic [ADDR_W-1:0] phys_a [NPORT];
  logic              ok_a   [NPORT];
  logic [ADDR_W-1:0] rd_phys [NRD];
  logic [DATA_W-1:0] rd_raw  [NRD];
  logic [DATA_W-1:0] rd_out  [NRD];

  rrf_base_ctr #(.BASE_W(BASE_W)) u_base (
    .clk      (clk),
    .rst      (rst),
    .base_clr (base_clr),
    .rot_en   (rot_en),
    .base_q   (base_q)
  );

  assign log_a[0] = wr_addr;
  assign log_a[1] = rd0_addr;
  assign log_a[2] = rd1_addr;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    rrf_map #(
      .ADDR_W(ADDR_W), .ROT_START(ROT_START),
      .ROT_SIZE(ROT_SIZE), .BASE_W(BASE_W)
    ) u_map (
      .log_addr  (log_a[p]),
      .base      (base_q),
      .phys_addr (phys_a[p]),
      .in_range  (ok_a[p])
    );
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rdsel
    assign rd_phys[r] = phys_a[r+1];
    assign rd_out[r]  = ok_a[r+1] ? rd_raw[r] : '0;
  end

  rrf_storage #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .NRD(NRD)
  ) u_mem (
    .clk   (clk),
    .we    (wr_en && ok_a[0]),
    .waddr (phys_a[0]),
    .wdata (wr_data),
    .raddr (rd_phys),
    .rdata (rd_raw)
  );

  assign rd0_data = rd_out[0];
  assign rd1_data = rd_out[1];
endmodule

// File: rtl/rrf_checker.sv
module rrf_checker #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 6,
  parameter int ROT_START = 32,
  parameter int ROT_SIZE  = 8,
  parameter int BASE_W    = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              rot_en,
  input logic              base_clr,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rd0_addr,
  input logic [DATA_W-1:0] rd0_data,
  input logic [ADDR_W-1:0] rd1_addr,
  input logic [DATA_W-1:0] rd1_data,
  input logic [BASE_W-1:0] base_q
);
  localparam logic [ADDR_W:0] TOP = (ADDR_W+1)'(ROT_START + ROT_SIZE);
  localparam logic [ADDR_W-1:0] W0 = ADDR_W'(ROT_START);

  initial begin
    AST_SIZE_POW2: assert (ROT_SIZE >= 2 && (ROT_SIZE & (ROT_SIZE - 1)) == 0); // R2
  end

  AST_BASE_RESET: assert property (@(posedge clk)
    rst |=> base_q == '0); // R9

  AST_BASE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    base_clr |=> base_q == '0); // R7

  AST_BASE_STEP: assert property (@(posedge clk) disable iff (rst)
    (rot_en && !base_clr) |=> base_q == BASE_W'($past(base_q) - 1'b1)); // R3

  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rot_en && !base_clr) |=> $stable(base_q)); // R3

  AST_OOR_ZERO: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, rd0_addr} >= TOP) |-> rd0_data == '0); // R8

  AST_WR_ROT: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en && wr_addr == W0 && rot_en && !base_clr && !rst)
     && rd0_addr == W0 + 1'b1) |-> rd0_data == $past(wr_data)); // R5

  AST_STATIC_RW: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en && wr_addr < W0) && rd1_addr == $past(wr_addr))
      |-> rd1_data == $past(wr_data)); // R1
endmodule

bind rrf_rotating_file rrf_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ROT_START(ROT_START),
  .ROT_SIZE(ROT_SIZE), .BASE_W(BASE_W)
) u_chk (.*);

// File: tb/rrf_rotating_file_test.sv
module rrf_rotating_file_test;
  localparam int DW = 32;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rot_en = 1'b0, base_clr = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd0_addr = '0, rd1_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd0_data, rd1_data;

  int n_run = 0, n_fail = 0;
  localparam logic [DW-1:0] A = 32'hA000_0000;
  localparam logic [DW-1:0] W = 32'h5EED_0001;
  localparam logic [DW-1:0] V = 32'h0BAD_CAFE;

  always #2 clk = ~clk;  // 250 MHz

  rrf_rotating_file uut (
    .clk(clk), .rst(rst), .rot_en(rot_en), .base_clr(base_clr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd0_addr(rd0_addr), .rd0_data(rd0_data),
    .rd1_addr(rd1_addr), .rd1_data(rd1_data)
  );

  task automatic check(input string req, input logic [DW-1:0] got,
                       input logic [DW-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic write(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rotate(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rot_en = 1'b1;
      @(negedge clk); rot_en = 1'b0;
    end
  endtask

  task automatic rd0(input int a, input string req, input logic [DW-1:0] exp);
    rd0_addr = AW'(a); #1;
    check(req, rd0_data, exp);
  endtask

  task automatic rd1(input int a, input string req, input logic [DW-1:0] exp);
    rd1_addr = AW'(a); #1;
    check(req, rd1_data, exp);
  endtask

  // R2 R9: base 0 after reset, window values read back at their names
  task automatic t_fill;
    for (int i = 0; i < 8; i++) write(32 + i, A + DW'(i));
    for (int i = 0; i < 8; i++) rd0(32 + i, "R2 window readback", A + DW'(i));
    rd1(37, "R2 second port", A + 5);
  endtask

  // R1: static registers ignore rotation
  task automatic t_static;
    write(5, 32'h0000_0505);
    write(31, 32'h0000_3131);
    rotate(3);
    rd0(5, "R1 static reg 5", 32'h0000_0505);
    rd1(31, "R1 static reg 31", 32'h0000_3131);
    rotate(5);  // back to base 0
    rd0(32, "R10 eight rotations identity", A);
  endtask

  // R3 R4: one rotation shifts names up, top wraps to bottom
  task automatic t_rotate_once;
    rotate(1);
    rd0(33, "R3 33 after rotate", A + 0);
    rd1(39, "R3 39 after rotate", A + 6);
    rd0(32, "R4 wrap top to 32", A + 7);
  endtask

  // R10: rest of a full turn restores identity
  task automatic t_full_turn;
    rotate(7);
    rd0(32, "R10 full turn 32", A + 0);
    rd1(39, "R10 full turn 39", A + 7);
  endtask

  // R5: write and rotate together, base 0 -> 7
  task automatic t_wr_rot;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(32); wr_data = W; rot_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rot_en = 1'b0;
    rd0(33, "R5 write lands pre-rotate", W);
    rd1(32, "R5 32 shows old top", A + 7);
  endtask

  // R6: same-cycle read sees old value, new value after the edge (base 7)
  task automatic t_rd_wr_same;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(34); wr_data = V; rd0_addr = AW'(34);
    #1 check("R6 old value during write", rd0_data, A + 1);
    @(negedge clk);
    wr_en = 1'b0; #1;
    check("R6 new value after edge", rd0_data, V);
  endtask

  // R7: clear beats rotate, data untouched
  task automatic t_clear;
    @(negedge clk); base_clr = 1'b1; rot_en = 1'b1;
    @(negedge clk); base_clr = 1'b0; rot_en = 1'b0;
    rd0(32, "R7 base zero entry 32", W);
    rd1(33, "R7 base zero entry 33", V);
    rd0(39, "R7 base zero entry 39", A + 7);
  endtask

  // R8: out-of-range writes dropped, reads zero
  task automatic t_oor;
    write(45, 32'hDEAD_BEEF);
    write(63, 32'hDEAD_BEEF);
    rd0(45, "R8 read 45 zero", '0);
    rd1(63, "R8 read 63 zero", '0);
    rd0(40, "R8 read 40 zero", '0);
    for (int i = 0; i < 8; i++) begin
      logic [DW-1:0] e;
      e = (i == 0) ? W : (i == 1) ? V : A + DW'(i);
      rd1(32 + i, "R8 window untouched", e);
    end
    rd0(5, "R8 static untouched", 32'h0000_0505);
  endtask

  // R9: reset mid-run clears base, keeps data
  task automatic t_reset_mid;
    rotate(2);
    rd0(34, "R3 two rotations", W);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd0(32, "R9 reset base zero", W);
    rd1(33, "R9 data kept", V);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_fill;
    t_static;
    t_rotate_once;
    t_full_turn;
    t_wr_rot;
    t_rd_wr_same;
    t_clear;
    t_oor;
    t_reset_mid;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule